// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block turns a stereo PCM bit stream into parallel sample words. It watches a bit clock, a frame clock and one serial data line. On each active bit clock edge it takes one data bit and one frame clock level. It delivers a left and a right word, each sign-extended to 32 bits, with a single-cycle valid pulse once per frame. The bit clock is not used as a clock. The block runs on one system clock and finds bit clock edges by comparing two registered copies of the bit clock.

Configuration pins choose one of four framings: right justified, left justified, I2S, or a DSP pulse-sync framing. They also choose the bit clock edge, the word length and a polarity control. In the three level-framed modes the polarity control swaps which frame clock level carries the left channel. In DSP mode it picks the early or the late variant. The configuration must stay static between resets.

A framer state machine has five states. HUNT waits for the first frame boundary. LEAD discards the one delay bit of I2S and early DSP. SHIFT counts the data bits of a word. GAP idles until the next boundary. RJRUN serves right justified mode, where the word is taken at the boundary that ends it. The transitions are:
- HUNT→RJRUN on the first boundary in right justified mode.
- Any state except RJRUN → LEAD on a boundary in I2S or early DSP.
- Any state except RJRUN → SHIFT on a boundary in left justified or late DSP.
- LEAD→SHIFT on the next bit.
- SHIFT→SHIFT when a DSP left word ends and the right word begins.
- SHIFT→GAP when the last word of a half or frame completes.
- GAP→LEAD or GAP→SHIFT on the next boundary.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is asserted and until the first valid pulse, both sample outputs are zero and the valid output is low.
- R2: With format 10 (I2S) and polarity 0, frame clock low marks the left channel. The MSB is the second bit sampled after a frame clock transition.
- R3: With format 01 (left justified) and polarity 0, frame clock high marks the left channel. The MSB is the first bit sampled after a frame clock transition.
- R4: With format 00 (right justified) and polarity 0, frame clock high marks the left channel. The LSB is the last bit sampled before the next frame clock transition, and earlier padding bits are ignored.
- R5: With format 00 and word length 11, the word is taken as 24 bits, not 32.
- R6: In formats 00, 01 and 10, polarity 1 swaps which frame clock level marks the left channel.
- R7: With format 11 and polarity 1 (late DSP), the left MSB is the bit sampled together with the first high sample of the frame sync. The right word follows the left word's LSB immediately.
- R8: With format 11 and polarity 0 (early DSP), the left MSB is the bit sampled one bit clock after the first high sync sample. The right word follows immediately.
- R9: With bit clock polarity 0, frame clock and data are sampled on the rising bit clock edge. With polarity 1 they are sampled on the falling edge.
- R10: Word length 00/01/10/11 selects 16/20/24/32 bits, received MSB first. Each output is the word sign-extended from its top bit to 32 bits.
- R11: Valid pulses high for exactly one system clock after each completed right word. Both outputs change only in that cycle and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk | input | 1 | Serial bit clock, sampled as data |
| frame_clk | input | 1 | Frame (LR) clock or DSP frame sync |
| ser_data | input | 1 | Serial audio data |
| cfg_fmt | input | 2 | Framing: 00 right justified, 01 left justified, 10 I2S, 11 DSP |
| cfg_pol | input | 1 | Frame clock polarity (level modes) or DSP early/late select |
| cfg_bclk_inv | input | 1 | 1 moves sampling to the falling bit clock edge |
| cfg_wlen | input | 2 | Word length: 00 16, 01 20, 10 24, 11 32 bits |
| left_smp | output | 32 | Left sample, sign-extended |
| right_smp | output | 32 | Right sample, sign-extended |
| smp_valid | output | 1 | One-cycle pulse when a new frame pair is presented |

## Verification
If the bit counter or the LEAD handling is off by one, the next valid pulse shows a word shifted by one bit position. That shows up as a doubled or halved value with a wrong sign extension, and it appears within one frame. If a boundary is missed or the channel flag is wrong, the valid pulse is missing or left and right are swapped. The bench detects this at the end of each configuration group as a wrong pulse count, or at the first compared frame. Random padding bits in every slot outside the word make a capture window that is too wide visible as corrupted upper bits.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

    localparam int SMP_W = 32;

    localparam logic [1:0] FMT_RJ  = 2'b00;
    localparam logic [1:0] FMT_LJ  = 2'b01;
    localparam logic [1:0] FMT_I2S = 2'b10;
    localparam logic [1:0] FMT_DSP = 2'b11;

    typedef enum logic [2:0] {
        ST_HUNT  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_SHIFT = 3'd2,
        ST_GAP   = 3'd3,
        ST_RJRUN = 3'd4
    } frm_state_e;

    // Effective word width; 32 requested in right justified falls to 24.
    function automatic logic [5:0] eff_width(input logic [1:0] wl, input logic [1:0] fmt);
        logic [5:0] w;
        unique case (wl)
            2'b00:   w = 6'd16;
            2'b01:   w = 6'd20;
            2'b10:   w = 6'd24;
            default: w = (fmt == FMT_RJ) ? 6'd24 : 6'd32;
        endcase
        return w;
    endfunction

    // Replicate bit w-1 of raw into every higher position.
    function automatic logic [SMP_W-1:0] sext(input logic [SMP_W-1:0] raw, input logic [5:0] w);
        logic [SMP_W-1:0] res;
        logic             top;
        top = raw[5'(w - 6'd1)];
        for (int i = 0; i < SMP_W; i++) begin
            res[i] = (i < int'(w)) ? raw[i] : top;
        end
        return res;
    endfunction

endpackage

// File: rtl/asrx_bitclk.sv
module asrx_bitclk (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_clk,
    input  logic frame_clk,
    input  logic ser_data,
    input  logic bclk_inv,
    output logic samp_en,
    output logic lr_s,
    output logic d_s
);

    logic sck_q1, sck_q2, lr_q1, d_q1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q1 <= 1'b0;
            sck_q2 <= 1'b0;
            lr_q1  <= 1'b0;
            d_q1   <= 1'b0;
        end else begin
            sck_q1 <= bit_clk;
            sck_q2 <= sck_q1;
            lr_q1  <= frame_clk;
            d_q1   <= ser_data;
        end
    end

    always_comb begin
        if (bclk_inv) samp_en = sck_q2 & ~sck_q1;
        else          samp_en = sck_q1 & ~sck_q2;
    end

    assign lr_s = lr_q1;
    assign d_s  = d_q1;

    // R9: one sample per bit clock edge, never on adjacent cycles
    assert_single_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
        samp_en |=> !samp_en);

endmodule

// File: rtl/asrx_framer.sv
module asrx_framer
    import asrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             lr,
    input  logic             d,
    input  logic [1:0]       fmt,
    input  logic             pol,
    input  logic [1:0]       wlen,
    output logic [SMP_W-1:0] cap_left,
    output logic [SMP_W-1:0] cap_right,
    output logic             done
);

    frm_state_e       state, state_d;
    logic [5:0]       cnt, cnt_d;
    logic             chan, chan_d;
    logic [SMP_W-1:0] sr;
    logic             lr_prev, have_prev;

    logic [5:0]       w;
    logic             is_dsp, lead, bnd, right_now;
    logic             cap_l, cap_r;
    logic [SMP_W-1:0] word_c;

    assign w         = eff_width(wlen, fmt);
    assign is_dsp    = (fmt == FMT_DSP);
    assign lead      = (fmt == FMT_I2S) || (is_dsp && !pol);
    assign right_now = lr ^ pol ^ (fmt != FMT_I2S);
    assign bnd       = have_prev && (is_dsp ? (lr && !lr_prev) : (lr != lr_prev));

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        chan_d  = chan;
        cap_l   = 1'b0;
        cap_r   = 1'b0;
        word_c  = sext({sr[SMP_W-2:0], d}, w);
        if (en) begin
            if (fmt == FMT_RJ) begin
                word_c = sext(sr, w);
                unique case (state)
                    ST_HUNT: begin
                        if (bnd) state_d = ST_RJRUN;
                    end
                    ST_RJRUN: begin
                        if (bnd) begin
                            if (right_now) cap_l = 1'b1;
                            else           cap_r = 1'b1;
                        end
                    end
                    default: state_d = ST_HUNT;
                endcase
            end else if (bnd) begin
                chan_d = is_dsp ? 1'b0 : right_now;
                if (lead) begin
                    state_d = ST_LEAD;
                    cnt_d   = 6'd0;
                end else begin
                    state_d = ST_SHIFT;
                    cnt_d   = 6'd1;
                end
            end else begin
                unique case (state)
                    ST_LEAD: begin
                        state_d = ST_SHIFT;
                        cnt_d   = 6'd1;
                    end
                    ST_SHIFT: begin
                        if (cnt == w - 6'd1) begin
                            if (chan) cap_r = 1'b1;
                            else      cap_l = 1'b1;
                            if (is_dsp && !chan) begin
                                chan_d = 1'b1;
                                cnt_d  = 6'd0;
                            end else begin
                                state_d = ST_GAP;
                            end
                        end else begin
                            cnt_d = cnt + 6'd1;
                        end
                    end
                    ST_HUNT, ST_GAP: begin
                        state_d = state;
                    end
                    default: state_d = ST_HUNT;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            cnt   <= 6'd0;
            chan  <= 1'b0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            chan  <= chan_d;
        end
    end

    // data path and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr        <= '0;
            lr_prev   <= 1'b0;
            have_prev <= 1'b0;
            cap_left  <= '0;
            cap_right <= '0;
            done      <= 1'b0;
        end else begin
            done <= cap_r;
            if (en) begin
                sr        <= {sr[SMP_W-2:0], d};
                lr_prev   <= lr;
                have_prev <= 1'b1;
            end
            if (cap_l) cap_left  <= word_c;
            if (cap_r) cap_right <= word_c;
        end
    end

    // R10: bit counter never passes the selected word length
    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (cnt < w));

    // R11: a completed frame is reported only after a bit was taken
    assert_done_after_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(en));

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import asrx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_clk,
    input  logic        frame_clk,
    input  logic        ser_data,
    input  logic [1:0]  cfg_fmt,
    input  logic        cfg_pol,
    input  logic        cfg_bclk_inv,
    input  logic [1:0]  cfg_wlen,
    output logic [31:0] left_smp,
    output logic [31:0] right_smp,
    output logic        smp_valid
);

    logic             samp_en, lr_s, d_s, done;
    logic [SMP_W-1:0] cap_left, cap_right;

    asrx_bitclk u_bitclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_clk   (bit_clk),
        .frame_clk (frame_clk),
        .ser_data  (ser_data),
        .bclk_inv  (cfg_bclk_inv),
        .samp_en   (samp_en),
        .lr_s      (lr_s),
        .d_s       (d_s)
    );

    asrx_framer u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (samp_en),
        .lr        (lr_s),
        .d         (d_s),
        .fmt       (cfg_fmt),
        .pol       (cfg_pol),
        .wlen      (cfg_wlen),
        .cap_left  (cap_left),
        .cap_right (cap_right),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_smp  <= '0;
            right_smp <= '0;
            smp_valid <= 1'b0;
        end else begin
            smp_valid <= done;
            if (done) begin
                left_smp  <= cap_left;
                right_smp <= cap_right;
            end
        end
    end

    logic [5:0] w_chk;
    assign w_chk = eff_width(cfg_wlen, cfg_fmt);

    // R11: strobe lasts one cycle
    assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    // R11: outputs hold between strobes
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |-> ($stable(left_smp) && $stable(right_smp)));

    // R10: outputs sign-extended from the effective top bit
    assert_sext_R10: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> ((($countones(left_smp >> (w_chk - 6'd1)) == 0) ||
                        ($countones(left_smp >> (w_chk - 6'd1)) == 33 - int'(w_chk))) &&
                       (($countones(right_smp >> (w_chk - 6'd1)) == 0) ||
                        ($countones(right_smp >> (w_chk - 6'd1)) == 33 - int'(w_chk)))));

    // R9: strobe follows a bit sample by two register stages
    assert_strobe_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(samp_en, 2));

endmodule

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_clk = 1'b0;
    logic        frame_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic [1:0]  cfg_fmt = 2'b10;
    logic        cfg_pol = 1'b0;
    logic        cfg_bclk_inv = 1'b0;
    logic [1:0]  cfg_wlen = 2'b00;
    logic [31:0] left_smp, right_smp;
    logic        smp_valid;

    always #5 clk = ~clk;

    audio_serial_rx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_clk(frame_clk),
        .ser_data(ser_data), .cfg_fmt(cfg_fmt), .cfg_pol(cfg_pol),
        .cfg_bclk_inv(cfg_bclk_inv), .cfg_wlen(cfg_wlen),
        .left_smp(left_smp), .right_smp(right_smp), .smp_valid(smp_valid)
    );

    int total = 0;
    int bad = 0;
    logic [31:0] exp_l [0:7];
    logic [31:0] exp_r [0:7];
    int wr_i = 0;
    int rd_i = 0;
    int hold_bad = 0;
    int g_w, g_slots;
    string g_tag;
    logic [31:0] pl = 0, pr = 0;
    logic pv = 0;

    function automatic int bw(input int fmt, input int wl);
        case (wl)
            0: return 16;
            1: return 20;
            2: return 24;
            default: return (fmt == 0) ? 24 : 32; // R5 fallback
        endcase
    endfunction

    function automatic logic [31:0] sx(input logic [31:0] v, input int w);
        logic [31:0] t;
        t = v << (32 - w);
        return 32'($signed(t) >>> (32 - w));
    endfunction

    function automatic string tag_for(input int fmt, input int pol, input int bi);
        string s;
        case (fmt)
            0: s = (cfg_wlen == 2'b11) ? "R4 R5" : "R4";
            1: s = "R3";
            2: s = "R2";
            default: s = pol ? "R7" : "R8";
        endcase
        if (fmt != 3 && pol != 0) s = {s, " R6"};
        if (bi != 0) s = {s, " R9"};
        return {s, " R10"};
    endfunction

    // monitor: compare strobed pairs, watch hold and pulse width (R11)
    always @(negedge clk) begin
        if (rst_n) begin
            if (!smp_valid && (left_smp != pl || right_smp != pr)) hold_bad++;
            if (smp_valid && pv) hold_bad++;
            if (smp_valid) begin
                total++;
                if (rd_i >= wr_i) begin
                    bad++;
                    $display("FAIL R11 extra strobe: actual=strobe#%0d expected=%0d strobes", rd_i + 1, wr_i);
                end else if (left_smp !== exp_l[rd_i] || right_smp !== exp_r[rd_i]) begin
                    bad++;
                    $display("FAIL %s frame %0d: actual L=%h R=%h expected L=%h R=%h",
                             g_tag, rd_i, left_smp, right_smp, exp_l[rd_i], exp_r[rd_i]);
                end
                rd_i++;
            end
        end
        pl = left_smp;
        pr = right_smp;
        pv = smp_valid;
    end

    task automatic slot(input logic lv, input logic dv);
        @(negedge clk);
        bit_clk   = cfg_bclk_inv;
        frame_clk = lv;
        ser_data  = dv;
        repeat (4) @(negedge clk);
        bit_clk = ~cfg_bclk_inv;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_frame(input logic [31:0] lw, input logic [31:0] rw);
        int fmt, w, off;
        logic llev, dv;
        fmt = int'(cfg_fmt);
        w = g_w;
        exp_l[wr_i] = sx(lw, w);
        exp_r[wr_i] = sx(rw, w);
        wr_i++;
        if (fmt == 3) begin
            off = cfg_pol ? 0 : 1;
            for (int i = 0; i < 2 * w + off + 2; i++) begin
                int k = i - off;
                dv = 1'($urandom());
                if (k >= 0 && k < w) dv = lw[w - 1 - k];
                else if (k >= w && k < 2 * w) dv = rw[2 * w - 1 - k];
                slot(i == 0, dv);
            end
        end else begin
            llev = ((fmt == 2) ? 1'b0 : 1'b1) ^ cfg_pol;
            for (int h = 0; h < 2; h++) begin
                logic [31:0] word = h ? rw : lw;
                for (int i = 0; i < g_slots; i++) begin
                    dv = 1'($urandom());
                    if (fmt == 1 && i < w) dv = word[w - 1 - i];
                    if (fmt == 2 && i >= 1 && i <= w) dv = word[w - i];
                    if (fmt == 0 && i >= g_slots - w) dv = word[g_slots - 1 - i];
                    slot(h ? ~llev : llev, dv);
                end
            end
        end
    endtask

    task automatic run_group(input int fmt, input int pol, input int bi, input int wl);
        logic llev;
        logic [31:0] msk;
        @(negedge clk);
        rst_n = 1'b0;
        cfg_fmt = 2'(fmt);
        cfg_pol = 1'(pol);
        cfg_bclk_inv = 1'(bi);
        cfg_wlen = 2'(wl);
        bit_clk = 1'(bi);
        ser_data = 1'b0;
        llev = ((fmt == 2) ? 1'b0 : 1'b1) ^ 1'(pol);
        frame_clk = (fmt == 3) ? 1'b0 : ~llev;
        g_w = bw(fmt, wl);
        g_slots = g_w + 1 + int'($urandom() % 4);
        g_tag = tag_for(fmt, pol, bi);
        repeat (4) @(negedge clk);
        wr_i = 0;
        rd_i = 0;
        total++;
        if (left_smp !== 0 || right_smp !== 0 || smp_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: actual L=%h R=%h V=%b expected 0 0 0", left_smp, right_smp, smp_valid);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) slot(frame_clk, 1'b0);
        msk = (g_w == 32) ? 32'hFFFF_FFFF : ((32'd1 << g_w) - 1);
        send_frame(32'd1 << (g_w - 1), (32'd1 << (g_w - 1)) - 1); // corner: min / max
        send_frame($urandom() & msk, $urandom() & msk);
        send_frame($urandom() & msk, msk);                         // all ones = -1
        for (int i = 0; i < 4; i++) slot((fmt == 3) ? 1'b0 : llev, 1'b0);
        repeat (20) @(negedge clk);
        total++;
        if (rd_i != wr_i) begin // R11 one strobe per frame
            bad++;
            $display("FAIL R11 strobe count %s: actual=%0d expected=%0d", g_tag, rd_i, wr_i);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        for (int f = 0; f < 4; f++)
            for (int p = 0; p < 2; p++)
                for (int wl = 0; wl < 4; wl++)
                    run_group(f, p, ((f + p + wl) % 2 == 0) ? int'($urandom() % 2) : (wl % 2), wl);
        total++;
        if (hold_bad != 0) begin // R11 hold and pulse width
            bad++;
            $display("FAIL R11 hold/pulse: actual=%0d violations expected=0", hold_bad);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R11 watchdog: actual=hung expected=complete");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule